// File: doc/BRIEF.md
# Sector-Erasable Byte Flash Command Controller

This block makes an on-chip RAM array look like a small byte-wide, sector-erasable flash part. A host drives a strobe-style bus with chip enable, write enable and output enable, all active low, together with a 16-bit address and separate 8-bit input and output data. The block samples these pins in its own clock domain. A write cycle takes effect on the clock where write enable returns high while chip enable is still low. A read cycle starts on the clock where output enable falls while chip enable is low.

Bus writes form unlock-coded command sequences. The sequences start a timed byte program, a sector erase or a chip erase, and they also pause or continue an erase in progress. While an operation runs, reads return a status byte instead of array data. Software polls that byte until it stops changing and then reads the array. Erase first preprograms each selected byte to 0x00, waits a programmable delay, writes 0xFF, and then runs a verify pass that rewrites any byte that does not read 0xFF.

Each sector has its own protection input. A protected sector cannot be changed by any command.

Top module: `flash_ctrl`

## Requirements
- R1: After reset `dout` is 0x00. In read mode a read returns the array byte at the low `ARR_AW` address bits, and repeated reads of it return the same value.
- R2: The writes 0x555/0xAA, 0x2AA/0x55, 0x555/0xA0 followed by one address/data write store that data byte after `PROG_CYC` cycles. Only the low 11 address bits are compared for command addresses.
- R3: The status byte carries dq7 in bit 7, t6 in bit 6 and t2 in bit 2, with all other bits 0. While a program runs, bit 7 reads as the inverse of bit 7 of the data being written, and bit 6 inverts on each new read. Once the program ends, reads return array data.
- R4: The two unlock writes, 0x555/0x80, two more unlock writes and then 0x30 at any address inside a sector mark that sector for erase. Each further 0x30 write made within `WIN_CYC` cycles of the previous one marks another sector. When the window closes, every marked sector reads 0xFF and all other sectors keep their data. The sector index is the top log2(`NSECT`) bits of the array address.
- R5: The same six-write sequence ending in 0x555/0x10 erases every unprotected sector.
- R6: During an erase, status bit 7 reads 0. Bit 2 inverts on successive reads of a marked sector and holds its value on reads of an unmarked sector.
- R7: A 0xB0 write during an erase suspends it, and the erase makes no progress while suspended. Reads of unmarked sectors return array data. Reads of marked sectors return status with bit 6 still inverting on each read. A 0x30 write continues the erase to completion.
- R8: While suspended, a program sequence aimed at an unmarked sector programs that byte, and the block then returns to the suspended state.
- R9: When `prot[s]` is 1, program commands to sector s are ignored and erases leave sector s unchanged.
- R10: In a command sequence, a write that does not match the expected address/data pair returns the block to read mode, so the rest of that sequence has no effect. A 0xF0 write in read mode does the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low; a write takes effect when it rises |
| oe_n | input | 1 | Output enable, active low; a read cycle starts when it falls |
| addr | input | 16 | Byte address |
| din | input | 8 | Write data or command code |
| dout | output | 8 | Array data or status byte, registered |
| prot | input | NSECT | Per-sector protection, 1 = protected |

## Verification
The hardest state to reach is a program running inside a suspended erase. The bench has to open a sector-erase window, let the window close, and issue the suspend while the erase walker is still active. It then waits far longer than the remaining erase time, to show that the walker has stopped. After that it sends a full program sequence to an unmarked sector and polls that address. Finally it reads a marked sector and confirms that status bit 6 still inverts, which shows the block went back to the suspended state and not to read mode, before it sends the resume.

// File: rtl/flash_pkg.sv
package flash_pkg;

  typedef enum logic [2:0] {
    OP_IDLE, OP_PROG, OP_EWIN, OP_ERASE, OP_SUSP, OP_SPROG
  } op_e;

  typedef enum logic [2:0] {
    CS_IDLE, CS_U1, CS_U2, CS_PDATA, CS_E0, CS_E1, CS_E2
  } cs_e;

  typedef enum logic [1:0] {EP_PRE, EP_WAIT, EP_CLR, EP_VER} ep_e;

  localparam logic [10:0] ADR_A = 11'h555;
  localparam logic [10:0] ADR_B = 11'h2AA;
  localparam logic [7:0]  KEY_A = 8'hAA;
  localparam logic [7:0]  KEY_B = 8'h55;
  localparam logic [7:0]  C_PROG   = 8'hA0;
  localparam logic [7:0]  C_ERASE  = 8'h80;
  localparam logic [7:0]  C_CHIP   = 8'h10;
  localparam logic [7:0]  C_SECT   = 8'h30;
  localparam logic [7:0]  C_SUSP   = 8'hB0;

  // status byte: bit7 data-poll, bit6 run toggle, bit2 sector toggle
  function automatic logic [7:0] status_byte(input logic dq7, input logic t6,
                                             input logic t2);
    return {dq7, t6, 3'b000, t2, 2'b00};
  endfunction

  function automatic logic key_match(input logic [15:0] a, input logic [7:0] d,
                                     input logic [10:0] ka, input logic [7:0] kd);
    return (a[10:0] == ka) && (d == kd);
  endfunction

endpackage

// File: rtl/flash_bus_if.sv
module flash_bus_if (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  output logic wr_evt,
  output logic rd_evt
);
  logic we_d, oe_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_d <= 1'b1;
      oe_d <= 1'b1;
    end else begin
      we_d <= we_n;
      oe_d <= oe_n;
    end
  end

  assign wr_evt = !ce_n && we_n && !we_d;
  assign rd_evt = !ce_n && !oe_n && oe_d;
endmodule

// File: rtl/flash_toggle.sv
module flash_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_evt,
  input  logic active,
  input  logic marked,
  output logic t6,
  output logic t2
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t6 <= 1'b0;
      t2 <= 1'b0;
    end else if (rd_evt && active) begin
      t6 <= ~t6;
      if (marked) t2 <= ~t2;
    end
  end
endmodule

// File: rtl/flash_erase_walk.sv
module flash_erase_walk #(
  parameter int ARR_AW    = 10,
  parameter int NSECT     = 4,
  parameter int ERASE_CYC = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [NSECT-1:0]  marks,
  input  logic [7:0]        rbyte,
  output logic              we,
  output logic [ARR_AW-1:0] ptr,
  output logic [7:0]        wd,
  output logic              done
);
  import flash_pkg::*;
  localparam int SW = $clog2(NSECT);
  localparam int EW = $clog2(ERASE_CYC);
  localparam logic [ARR_AW-1:0] PLAST = '1;
  localparam logic [EW-1:0]     ELAST = EW'(ERASE_CYC - 1);

  ep_e         ph;
  logic [EW-1:0] cnt;
  logic        hit;

  assign hit  = marks[ptr[ARR_AW-1 -: SW]];
  assign done = run && (ph == EP_VER) && (ptr == PLAST);
  assign wd   = (ph == EP_PRE) ? 8'h00 : 8'hFF;
  assign we   = run && hit && ((ph == EP_PRE) || (ph == EP_CLR) ||
                               ((ph == EP_VER) && (rbyte != 8'hFF)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= EP_PRE;
      ptr <= '0;
      cnt <= '0;
    end else if (run) begin
      case (ph)
        EP_PRE: begin
          ptr <= ptr + 1'b1;
          if (ptr == PLAST) begin
            ph  <= EP_WAIT;
            cnt <= '0;
          end
        end
        EP_WAIT: begin
          cnt <= cnt + 1'b1;
          if (cnt == ELAST) ph <= EP_CLR;
        end
        EP_CLR: begin
          ptr <= ptr + 1'b1;
          if (ptr == PLAST) ph <= EP_VER;
        end
        default: begin
          ptr <= ptr + 1'b1;
          if (ptr == PLAST) ph <= EP_PRE;
        end
      endcase
    end
  end
endmodule

// File: rtl/flash_ctrl.sv
module flash_ctrl #(
  parameter int ARR_AW    = 10,
  parameter int NSECT     = 4,
  parameter int PROG_CYC  = 64,
  parameter int ERASE_CYC = 256,
  parameter int WIN_CYC   = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [15:0]      addr,
  input  logic [7:0]       din,
  output logic [7:0]       dout,
  input  logic [NSECT-1:0] prot
);
  import flash_pkg::*;
  localparam int DEPTH = 1 << ARR_AW;
  localparam int SW    = $clog2(NSECT);
  localparam int PW    = $clog2(PROG_CYC);
  localparam int WW    = $clog2(WIN_CYC);
  localparam logic [PW-1:0] PLAST = PW'(PROG_CYC - 1);
  localparam logic [WW-1:0] WLAST = WW'(WIN_CYC - 1);

  function automatic logic [SW-1:0] sect_of(input logic [ARR_AW-1:0] a);
    return a[ARR_AW-1 -: SW];
  endfunction

  logic [7:0] mem [DEPTH];

  op_e               op;
  cs_e               cs;
  logic [NSECT-1:0]  marks;
  logic [ARR_AW-1:0] pa;
  logic [7:0]        pd;
  logic [PW-1:0]     pcnt;
  logic [WW-1:0]     wcnt;

  logic              wr_evt, rd_evt, t6, t2;
  logic [ARR_AW-1:0] wa;
  logic [SW-1:0]     ws;
  logic              is_u1, is_u2, at_a;
  logic              p_we, e_we, er_done, mem_we;
  logic [ARR_AW-1:0] er_ptr, mem_wa;
  logic [7:0]        e_wd, mem_wd;
  logic              busy, show_stat, dq7;
  logic              unused_hi;

  assign unused_hi = ^addr;
  assign wa    = addr[ARR_AW-1:0];
  assign ws    = sect_of(wa);
  assign is_u1 = key_match(addr, din, ADR_A, KEY_A);
  assign is_u2 = key_match(addr, din, ADR_B, KEY_B);
  assign at_a  = (addr[10:0] == ADR_A);

  flash_bus_if u_bus (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .wr_evt(wr_evt), .rd_evt(rd_evt)
  );

  assign busy = (op != OP_IDLE);

  flash_toggle u_tgl (
    .clk(clk), .rst_n(rst_n), .rd_evt(rd_evt), .active(busy),
    .marked(marks[ws]), .t6(t6), .t2(t2)
  );

  flash_erase_walk #(.ARR_AW(ARR_AW), .NSECT(NSECT), .ERASE_CYC(ERASE_CYC)) u_walk (
    .clk(clk), .rst_n(rst_n), .run(op == OP_ERASE), .marks(marks),
    .rbyte(mem[er_ptr]), .we(e_we), .ptr(er_ptr), .wd(e_wd), .done(er_done)
  );

  assign p_we   = ((op == OP_PROG) || (op == OP_SPROG)) && (pcnt == PLAST);
  assign mem_we = p_we || e_we;
  assign mem_wa = p_we ? pa : er_ptr;
  assign mem_wd = p_we ? pd : e_wd;

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_wa] <= mem_wd;
  end

  // command sequencer and operation state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op <= OP_IDLE; cs <= CS_IDLE; marks <= '0;
      pa <= '0; pd <= '0; pcnt <= '0; wcnt <= '0;
    end else begin
      case (op)
        OP_IDLE, OP_SUSP: if (wr_evt) begin
          case (cs)
            CS_IDLE: if (is_u1) cs <= CS_U1;
                     else if (op == OP_SUSP && din == C_SECT) op <= OP_ERASE;
            CS_U1:   cs <= is_u2 ? CS_U2 : CS_IDLE;
            CS_U2:   if (at_a && din == C_PROG) cs <= CS_PDATA;
                     else if (op == OP_IDLE && at_a && din == C_ERASE) cs <= CS_E0;
                     else cs <= CS_IDLE;
            CS_PDATA: begin
              cs <= CS_IDLE;
              if (!prot[ws] && !(op == OP_SUSP && marks[ws])) begin
                pa   <= wa;
                pd   <= din;
                pcnt <= '0;
                op   <= (op == OP_SUSP) ? OP_SPROG : OP_PROG;
              end
            end
            CS_E0:   cs <= is_u1 ? CS_E1 : CS_IDLE;
            CS_E1:   cs <= is_u2 ? CS_E2 : CS_IDLE;
            CS_E2: begin
              cs <= CS_IDLE;
              if (at_a && din == C_CHIP) begin
                if (~prot != '0) begin
                  marks <= ~prot;
                  op    <= OP_ERASE;
                end
              end else if (din == C_SECT) begin
                marks     <= '0;
                marks[ws] <= ~prot[ws];
                wcnt      <= '0;
                op        <= OP_EWIN;
              end
            end
            default: cs <= CS_IDLE;
          endcase
        end
        OP_PROG, OP_SPROG: begin
          pcnt <= pcnt + 1'b1;
          if (pcnt == PLAST) op <= (op == OP_SPROG) ? OP_SUSP : OP_IDLE;
        end
        OP_EWIN: begin
          if (wr_evt) begin
            if (din == C_SECT) begin
              marks[ws] <= marks[ws] | ~prot[ws];
              wcnt      <= '0;
            end else begin
              op    <= OP_IDLE;
              marks <= '0;
            end
          end else if (wcnt == WLAST) begin
            op <= (marks == '0) ? OP_IDLE : OP_ERASE;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        OP_ERASE: begin
          if (er_done) begin
            op    <= OP_IDLE;
            marks <= '0;
          end else if (wr_evt && din == C_SUSP) begin
            op <= OP_SUSP;
          end
        end
        default: op <= OP_IDLE;
      endcase
    end
  end

  // read path
  assign show_stat = (op == OP_PROG) || (op == OP_SPROG) || (op == OP_EWIN) ||
                     (op == OP_ERASE) || ((op == OP_SUSP) && marks[ws]);
  assign dq7 = ((op == OP_PROG) || (op == OP_SPROG)) ? ~pd[7] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout <= 8'h00;
    else        dout <= show_stat ? status_byte(dq7, t6, t2) : mem[wa];
  end
endmodule

// File: rtl/flash_ctrl_chk.sv
module flash_ctrl_chk #(
  parameter int NSECT  = 4,
  parameter int ARR_AW = 10
) (
  input logic              clk,
  input logic              rst_n,
  input flash_pkg::op_e    op,
  input flash_pkg::cs_e    cs,
  input logic              wr_evt,
  input logic              rd_evt,
  input logic [7:0]        din,
  input logic              mem_we,
  input logic [NSECT-1:0]  marks,
  input logic              t6,
  input logic [ARR_AW-1:0] er_ptr
);
  import flash_pkg::*;

  // R10
  bad_second_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && op == OP_IDLE && cs == CS_U1 && din != 8'h55) |=> cs == CS_IDLE);

  // R3
  run_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && op != OP_IDLE) |=> t6 != $past(t6));

  // R2
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_IDLE) |-> !mem_we);

  // R7
  suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SUSP) |=> $stable(er_ptr));

  // R4
  idle_marks_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_IDLE) |-> marks == '0);
endmodule

bind flash_ctrl flash_ctrl_chk #(.NSECT(NSECT), .ARR_AW(ARR_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .cs(cs), .wr_evt(wr_evt),
  .rd_evt(rd_evt), .din(din), .mem_we(mem_we), .marks(marks), .t6(t6),
  .er_ptr(er_ptr)
);

// File: tb/tb_flash_ctrl.sv
module tb_flash_ctrl;
  localparam int NSECT = 4;
  localparam int PROG_CYC = 20;
  localparam int WIN_CYC = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic [NSECT-1:0] prot = '0;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  flash_ctrl #(.ARR_AW(8), .NSECT(NSECT), .PROG_CYC(PROG_CYC),
               .ERASE_CYC(50), .WIN_CYC(WIN_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .prot(prot)
  );

  // program vectors {address, data}; data always has a bit in 5:3 set
  localparam logic [23:0] VEC [6] = '{
    {16'h0005, 8'h3C}, {16'h004A, 8'h5A}, {16'h0047, 8'h18},
    {16'h0093, 8'h28}, {16'h00D1, 8'h6D}, {16'h00FE, 8'h08}
  };

  task automatic chk(input logic ok, input string req, input logic [7:0] act,
                     input logic [7:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(negedge clk);
    we_n = 1'b1;
    repeat (2) @(negedge clk);
    ce_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    repeat (3) @(negedge clk);
    d = dout; oe_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic unlock();
    bus_wr(16'h0555, 8'hAA);
    bus_wr(16'h02AA, 8'h55);
  endtask

  task automatic prog(input logic [15:0] a, input logic [7:0] d);
    unlock(); bus_wr(16'h0555, 8'hA0); bus_wr(a, d);
  endtask

  task automatic erase_pre();
    unlock(); bus_wr(16'h0555, 8'h80); unlock();
  endtask

  task automatic poll(input logic [15:0] a);
    logic [7:0] r1, r2;
    bus_rd(a, r1);
    for (int i = 0; i < 600; i++) begin
      bus_rd(a, r2);
      if (r2 == r1) break;
      r1 = r2;
    end
  endtask

  task automatic expect_rd(input logic [15:0] a, input logic [7:0] e, input string req);
    logic [7:0] r;
    bus_rd(a, r);
    chk(r == e, req, r, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] a1, a2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dout == 8'h00, "R1 reset", dout, 8'h00);

    // R5 chip erase from unknown contents
    erase_pre(); bus_wr(16'h0555, 8'h10);
    poll(16'h0000);
    expect_rd(16'h0000, 8'hFF, "R5 chip erase s0");
    expect_rd(16'h007F, 8'hFF, "R5 chip erase s1");
    expect_rd(16'h00FF, 8'hFF, "R5 chip erase s3");

    // R2 / R3 program table
    foreach (VEC[i]) begin
      prog(VEC[i][23:8], VEC[i][7:0]);
      if (i == 0) begin
        bus_rd(VEC[i][23:8], a1);
        bus_rd(VEC[i][23:8], a2);
        chk(a1[7] == ~VEC[i][7], "R3 dq7 inverse", {7'd0, a1[7]}, {7'd0, ~VEC[i][7]});
        chk(a1[6] != a2[6], "R3 bit6 toggles", a2, a1);
        chk((a1 & 8'h3B) == 8'h00, "R3 status zero bits", a1 & 8'h3B, 8'h00);
      end
      poll(VEC[i][23:8]);
      expect_rd(VEC[i][23:8], VEC[i][7:0], "R2 program data");
    end
    bus_rd(16'h0047, a1); bus_rd(16'h0047, a2);
    chk(a1 == a2, "R1 stable reads", a2, a1);

    // R4 / R6 sector erase of sectors 1 and 2
    erase_pre(); bus_wr(16'h0040, 8'h30); bus_wr(16'h0080, 8'h30);
    bus_rd(16'h004A, a1); bus_rd(16'h004A, a2);
    chk(a1[2] != a2[2], "R6 bit2 toggles marked", a2, a1);
    chk(a2[7] == 1'b0, "R6 dq7 zero in erase", a2, 8'h00);
    bus_rd(16'h0005, a1); bus_rd(16'h0005, a2);
    chk(a1[2] == a2[2], "R6 bit2 constant unmarked", a2, a1);
    poll(16'h004A);
    expect_rd(16'h004A, 8'hFF, "R4 s1 erased");
    expect_rd(16'h0047, 8'hFF, "R4 s1 erased");
    expect_rd(16'h0093, 8'hFF, "R4 s2 erased");
    expect_rd(16'h0005, 8'h3C, "R4 s0 kept");
    expect_rd(16'h00D1, 8'h6D, "R4 s3 kept");

    // R7 / R8 suspend, program during suspend, resume
    erase_pre(); bus_wr(16'h00C0, 8'h30);
    repeat (WIN_CYC + 20) @(negedge clk);
    bus_wr(16'h0000, 8'hB0);
    expect_rd(16'h0005, 8'h3C, "R7 unmarked read in suspend");
    repeat (1200) @(negedge clk);
    bus_rd(16'h00D1, a1); bus_rd(16'h00D1, a2);
    chk(a1[6] != a2[6], "R7 erase held in suspend", a2, a1);
    prog(16'h0010, 8'h2C);
    poll(16'h0010);
    expect_rd(16'h0010, 8'h2C, "R8 program in suspend");
    bus_rd(16'h00D1, a1); bus_rd(16'h00D1, a2);
    chk(a1[6] != a2[6], "R8 back to suspend", a2, a1);
    bus_wr(16'h0000, 8'h30);
    poll(16'h00D1);
    expect_rd(16'h00D1, 8'hFF, "R7 resumed erase s3");
    expect_rd(16'h00FE, 8'hFF, "R7 resumed erase s3");
    expect_rd(16'h0005, 8'h3C, "R7 s0 kept");

    // R9 protection
    prog(16'h0093, 8'h28); poll(16'h0093);
    prot = 4'b0100;
    erase_pre(); bus_wr(16'h0555, 8'h10);
    poll(16'h0005);
    expect_rd(16'h0093, 8'h28, "R9 protected survives chip erase");
    expect_rd(16'h0005, 8'hFF, "R9 unprotected erased");
    prog(16'h0093, 8'h18);
    repeat (PROG_CYC + 10) @(negedge clk);
    expect_rd(16'h0093, 8'h28, "R9 protected program ignored");
    prot = '0;

    // R10 broken sequence and reset command
    bus_wr(16'h0555, 8'hAA); bus_wr(16'h02AA, 8'h12);
    bus_wr(16'h0555, 8'hA0); bus_wr(16'h0020, 8'h18);
    repeat (PROG_CYC + 10) @(negedge clk);
    expect_rd(16'h0020, 8'hFF, "R10 broken sequence ignored");
    bus_wr(16'h0555, 8'hAA); bus_wr(16'h0000, 8'hF0);
    bus_wr(16'h0555, 8'hA0); bus_wr(16'h0021, 8'h3C);
    repeat (PROG_CYC + 10) @(negedge clk);
    expect_rd(16'h0021, 8'hFF, "R10 reset command");
    prog(16'h0021, 8'h3C); poll(16'h0021);
    expect_rd(16'h0021, 8'h3C, "R10 sequence after reset");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule